// File: doc/BRIEF.md
# Fractional Fixed-Point Multiply-Accumulate Unit

This block is the arithmetic core of a signal-processing datapath. It accepts two signed fractional operands and an opcode on every cycle. It forms the full double-width product and loads it into an accumulator, adds it to the accumulator or subtracts it from the accumulator. The accumulator carries extra guard bits above the product, so a long run of sums does not overflow before the result is written out.

A store path turns the accumulator into a single-width word. It discards the low half using one of three rounding rules, picked on each read. It then clamps to the largest or smallest representable fraction, if clamping is enabled. A sticky flag records that a clamp took place. The flag stays set until the accumulator is cleared. Each accepted operation produces a one-cycle valid pulse on the cycle after it is accepted.

Operands are Q1.(DW-1) fractions. The sign bit is followed directly by the binary point, so the value range is -1 up to, but not including, +1.

Top module: `fxp_mac`

## Requirements
- R1: Opcode 2'b00 (clear), accepted with `in_valid`, sets the accumulator to zero. At the same edge it clears `ovf_sticky`, and this takes priority over any set of the flag at that edge.
- R2: The product is the signed product of `a` and `b`, shifted left by one bit and kept at 2*DW bits. The single case 0x8000 × 0x8000 (-1 × -1) gives 2^(2*DW-1)-1 instead of overflowing.
- R3: Opcode 2'b01 loads the product, 2'b10 adds it and 2'b11 subtracts it. The result goes into an accumulator of 2*DW+GUARD bits that wraps in two's complement at that width.
- R4: `result` is formed from the accumulator held in the register, read as value/2^DW. With `rnd_mode` 2'b00 or 2'b11 the value is rounded toward minus infinity (truncation).
- R5: With `rnd_mode` 2'b01, a discarded fraction of one half or more rounds up, and a smaller fraction rounds down.
- R6: With `rnd_mode` 2'b10, a discarded fraction above one half rounds up and one below one half rounds down. An exact half rounds so that the result LSB is zero.
- R7: With `sat_en` high, a rounded value above 0x7FFF gives 0x7FFF and one below -0x8000 gives 0x8000. With `sat_en` low, the low DW bits of the rounded value are output.
- R8: `ovf_sticky` goes high on the edge that ends a cycle in which `out_valid` is high and the output is clamped. It then holds until a clear (R1).
- R9: `out_valid` is high exactly on the cycle after `in_valid` was sampled high. With `in_valid` low, the opcode and operands have no effect on the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation accepted this cycle |
| op | input | 2 | 00 clear, 01 multiply, 10 accumulate, 11 accumulate-subtract |
| a | input | DW | Operand, signed fraction |
| b | input | DW | Operand, signed fraction |
| rnd_mode | input | 2 | 00 truncate, 01 round half up, 10 convergent, 11 truncate |
| sat_en | input | 1 | Clamp the stored word on overflow |
| out_valid | output | 1 | Pulses the cycle after an accepted operation |
| result | output | DW | Rounded (and optionally clamped) accumulator word |
| ovf_sticky | output | 1 | A clamped result has been presented since the last clear |

## Verification
The hardest conditions to reach from the ports are a discarded fraction of exactly one half and an accumulator that has outgrown the guard-free range. Random operands almost never produce either one. The stimulus builds exact halves on purpose: it multiplies small integers by 0x4000, which places the tie at bit DW-1 with the kept LSB either odd or even, and it does this for both signs. It reaches out-of-range values by accumulating two near-full-scale negative products. Because the store path reads the register combinationally, the bench sweeps every rounding mode and clamp setting over the same accumulator value inside one output window. It compares each sweep against a wide-integer model.

// File: rtl/fxp_mac_pkg.sv
package fxp_mac_pkg;

   typedef enum logic [1:0] {
      OPC_CLEAR = 2'b00,
      OPC_LOAD  = 2'b01,
      OPC_ADD   = 2'b10,
      OPC_SUB   = 2'b11
   } mac_opc_e;

   typedef enum logic [1:0] {
      RM_TRUNC   = 2'b00,
      RM_HALF_UP = 2'b01,
      RM_EVEN    = 2'b10,
      RM_TRUNC2  = 2'b11
   } round_mode_e;

endpackage

// File: rtl/fxp_frac_mult.sv
module fxp_frac_mult #(
   parameter int DW   = 16,
   parameter bit FRAC = 1'b1
) (
   input  logic [DW-1:0]   a,
   input  logic [DW-1:0]   b,
   output logic [2*DW-1:0] prod
);
   localparam int PW = 2 * DW;

   logic signed [PW-1:0] ea;
   logic signed [PW-1:0] eb;
   logic signed [PW-1:0] raw;

   initial begin
      assert (DW >= 2) else $error("fxp_frac_mult: DW must be at least 2");
   end

   always_comb begin
      ea  = PW'($signed(a));
      eb  = PW'($signed(b));
      raw = ea * eb;
   end

   generate
      if (FRAC) begin : g_frac
         localparam logic [DW-1:0] NEG_ONE  = {1'b1, {(DW-1){1'b0}}};
         localparam logic [PW-1:0] PROD_MAX = {1'b0, {(PW-1){1'b1}}};
         logic both_neg_one;
         assign both_neg_one = (a == NEG_ONE) && (b == NEG_ONE);
         assign prod = both_neg_one ? PROD_MAX : {raw[PW-2:0], 1'b0};
      end else begin : g_int
         assign prod = raw;
      end
   endgenerate
endmodule

// File: rtl/fxp_acc.sv
module fxp_acc #(
   parameter int DW    = 16,
   parameter int GUARD = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [1:0]              op,
   input  logic [2*DW-1:0]         prod,
   output logic [2*DW+GUARD-1:0]   acc_q
);
   import fxp_mac_pkg::*;

   localparam int PW = 2 * DW;
   localparam int AW = PW + GUARD;

   logic [AW-1:0] prod_ext;
   logic [AW-1:0] acc_d;

   initial begin
      assert (GUARD >= 0) else $error("fxp_acc: GUARD must not be negative");
   end

   assign prod_ext = AW'($signed(prod));

   always_comb begin
      acc_d = acc_q;
      if (in_valid) begin
         case (mac_opc_e'(op))
            OPC_CLEAR: acc_d = '0;
            OPC_LOAD:  acc_d = prod_ext;
            OPC_ADD:   acc_d = acc_q + prod_ext;
            OPC_SUB:   acc_d = acc_q - prod_ext;
            default:   acc_d = acc_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_d;
   end

   // R1: an accepted clear leaves a zero accumulator
   assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OPC_CLEAR) |=> (acc_q == '0));

   // R9: without in_valid the accumulator keeps its value
   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(acc_q));
endmodule

// File: rtl/fxp_store.sv
module fxp_store #(
   parameter int DW    = 16,
   parameter int GUARD = 8
) (
   input  logic [2*DW+GUARD-1:0] acc,
   input  logic [1:0]            rnd_mode,
   input  logic                  sat_en,
   output logic [DW-1:0]         result,
   output logic                  sat_hit
);
   import fxp_mac_pkg::*;

   localparam int AW = 2 * DW + GUARD;
   localparam int KW = AW - DW;
   localparam logic [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};
   localparam logic [DW-1:0] NEG_MAX = {1'b1, {(DW-1){1'b0}}};

   logic [KW-1:0] kept;
   logic [DW-1:0] frac;
   logic          at_half;
   logic          above_half;
   logic          inc;
   logic [KW:0]   rounded;
   logic          too_big;
   logic          too_small;

   initial begin
      assert (KW >= DW) else $error("fxp_store: accumulator narrower than 2*DW");
   end

   assign kept       = acc[AW-1:DW];
   assign frac       = acc[DW-1:0];
   assign at_half    = frac[DW-1] && !(|frac[DW-2:0]);
   assign above_half = frac[DW-1] && (|frac[DW-2:0]);

   always_comb begin
      case (round_mode_e'(rnd_mode))
         RM_HALF_UP: inc = frac[DW-1];
         RM_EVEN:    inc = above_half || (at_half && kept[0]);
         default:    inc = 1'b0;
      endcase
   end

   assign rounded   = {kept[KW-1], kept} + {{KW{1'b0}}, inc};
   assign too_big   = !rounded[KW] && (|rounded[KW:DW-1]);
   assign too_small =  rounded[KW] && !(&rounded[KW:DW-1]);
   assign sat_hit   = sat_en && (too_big || too_small);

   always_comb begin
      if (sat_en && too_big)        result = POS_MAX;
      else if (sat_en && too_small) result = NEG_MAX;
      else                          result = rounded[DW-1:0];
   end
endmodule

// File: rtl/fxp_mac.sv
module fxp_mac #(
   parameter int DW    = 16,
   parameter int GUARD = 8,
   parameter bit FRAC  = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [1:0]    op,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic [1:0]    rnd_mode,
   input  logic          sat_en,
   output logic          out_valid,
   output logic [DW-1:0] result,
   output logic          ovf_sticky
);
   import fxp_mac_pkg::*;

   localparam int PW = 2 * DW;
   localparam int AW = PW + GUARD;
   localparam logic [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};
   localparam logic [DW-1:0] NEG_MAX = {1'b1, {(DW-1){1'b0}}};

   logic [PW-1:0] prod;
   logic [AW-1:0] acc_q;
   logic          sat_hit;
   logic          clear_now;

   fxp_frac_mult #(.DW(DW), .FRAC(FRAC)) u_mult (
      .a    (a),
      .b    (b),
      .prod (prod)
   );

   fxp_acc #(.DW(DW), .GUARD(GUARD)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .op       (op),
      .prod     (prod),
      .acc_q    (acc_q)
   );

   fxp_store #(.DW(DW), .GUARD(GUARD)) u_store (
      .acc      (acc_q),
      .rnd_mode (rnd_mode),
      .sat_en   (sat_en),
      .result   (result),
      .sat_hit  (sat_hit)
   );

   assign clear_now = in_valid && (op == OPC_CLEAR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         ovf_sticky <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (clear_now)                 ovf_sticky <= 1'b0;
         else if (out_valid && sat_hit) ovf_sticky <= 1'b1;
      end
   end

   // R2: product sign follows operand signs for nonzero operands
   assert_prod_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (a != '0 && b != '0 && !(a == NEG_MAX && b == NEG_MAX))
      |-> (prod[PW-1] == (a[DW-1] ^ b[DW-1])));

   // R4: truncation without clamping returns the upper accumulator half
   assert_trunc_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rnd_mode == RM_TRUNC && !sat_en) |-> (result == acc_q[PW-1:DW]));

   // R7: a clamp event always shows an extreme code
   assert_clamp_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sat_hit |-> (result == POS_MAX || result == NEG_MAX));

   // R8: the sticky flag holds until a clear
   assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_sticky && !clear_now) |=> ovf_sticky);

   // R9: one cycle of latency on the valid pulse
   assert_valid_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_valid_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
endmodule

// File: tb/test_fxp_mac.sv
module test_fxp_mac;
   localparam int CLK_PERIOD = 10;
   localparam int DW    = 16;
   localparam int GUARD = 8;
   localparam int AW    = 2 * DW + GUARD;
   localparam int NV    = 10;

   // {op, a, b, expected result with truncation and clamping}
   localparam logic [49:0] VEC [NV] = '{
      {2'b01, 16'h4000, 16'h4000, 16'h2000},
      {2'b10, 16'h4000, 16'h4000, 16'h4000},
      {2'b10, 16'h4000, 16'h4000, 16'h6000},
      {2'b11, 16'h2000, 16'h4000, 16'h5000},
      {2'b10, 16'h7FFF, 16'h7FFF, 16'h7FFF},
      {2'b00, 16'h1234, 16'h5678, 16'h0000},
      {2'b01, 16'h8000, 16'h8000, 16'h7FFF},
      {2'b01, 16'h8000, 16'h4000, 16'hC000},
      {2'b11, 16'h8000, 16'h4000, 16'h0000},
      {2'b01, 16'hFFFF, 16'h0001, 16'hFFFF}
   };

   logic          clk = 1'b0;
   logic          rst_n;
   logic          in_valid;
   logic [1:0]    op;
   logic [DW-1:0] a, b;
   logic [1:0]    rnd_mode;
   logic          sat_en;
   logic          out_valid;
   logic [DW-1:0] result;
   logic          ovf_sticky;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  finished = 1'b0;
   longint mdl_acc = 0;

   fxp_mac #(.DW(DW), .GUARD(GUARD), .FRAC(1'b1)) i_fxp_mac (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .op         (op),
      .a          (a),
      .b          (b),
      .rnd_mode   (rnd_mode),
      .sat_en     (sat_en),
      .out_valid  (out_valid),
      .result     (result),
      .ovf_sticky (ovf_sticky)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic longint wrap_acc(longint x);
      return (x <<< (64 - AW)) >>> (64 - AW);
   endfunction

   function automatic longint model_prod(logic [DW-1:0] x, logic [DW-1:0] y);
      longint sx = longint'($signed(x));
      longint sy = longint'($signed(y));
      if (x == 16'h8000 && y == 16'h8000) return (64'sd1 <<< (2 * DW - 1)) - 1;
      return (sx * sy) <<< 1;
   endfunction

   function automatic logic [DW-1:0] model_store(longint acc, int mode, bit sat);
      longint kept = acc >>> DW;
      longint frac = acc & ((64'sd1 <<< DW) - 1);
      longint half = 64'sd1 <<< (DW - 1);
      longint inc  = 0;
      longint r;
      if (mode == 1 && frac >= half) inc = 1;
      if (mode == 2 && (frac > half || (frac == half && kept[0]))) inc = 1;
      r = kept + inc;
      if (sat && r > half - 1) r = half - 1;
      if (sat && r < -half)    r = -half;
      return r[DW-1:0];
   endfunction

   task automatic check(input string req, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // called at a falling edge; returns at the falling edge of the output window
   task automatic step(input logic [1:0] o, input logic [DW-1:0] x, input logic [DW-1:0] y);
      longint p;
      in_valid = 1'b1;
      op = o;
      a  = x;
      b  = y;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      p = model_prod(x, y);
      case (o)
         2'b00:   mdl_acc = 0;
         2'b01:   mdl_acc = wrap_acc(p);
         2'b10:   mdl_acc = wrap_acc(mdl_acc + p);
         default: mdl_acc = wrap_acc(mdl_acc - p);
      endcase
   endtask

   task automatic sweep(input string req);
      for (int m = 0; m < 4; m++) begin
         for (int s = 1; s >= 0; s--) begin
            rnd_mode = m[1:0];
            sat_en   = s[0];
            #1;
            check(req, longint'(result), longint'(model_store(mdl_acc, m, s[0])));
         end
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; op = 2'b00; a = '0; b = '0;
      rnd_mode = 2'b00; sat_en = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("reset result", longint'(result), 0);
      check("reset R9 out_valid", longint'(out_valid), 0);
      check("reset R8 sticky", longint'(ovf_sticky), 0);

      // vector table: R2 R3 R4 R7
      for (int i = 0; i < NV; i++) begin
         rnd_mode = 2'b00;
         sat_en   = 1'b1;
         step(VEC[i][49:48], VEC[i][47:32], VEC[i][31:16]);
         check("R3 R4 R7 vector", longint'(result), longint'(VEC[i][15:0]));
         check("R9 valid pulse", longint'(out_valid), 1);
      end
      @(negedge clk);
      check("R9 valid drops", longint'(out_valid), 0);

      // exact-half and near-half rounding: R4 R5 R6
      sat_en = 1'b0;
      step(2'b01, 16'h0001, 16'h4000);
      rnd_mode = 2'b00; #1 check("R4 half even trunc", longint'(result), 16'h0000);
      rnd_mode = 2'b01; #1 check("R5 half even up",    longint'(result), 16'h0001);
      rnd_mode = 2'b10; #1 check("R6 half even conv",  longint'(result), 16'h0000);
      rnd_mode = 2'b11; #1 check("R4 mode3 trunc",     longint'(result), 16'h0000);
      @(negedge clk);
      step(2'b01, 16'h0003, 16'h4000);
      rnd_mode = 2'b00; #1 check("R4 half odd trunc", longint'(result), 16'h0001);
      rnd_mode = 2'b01; #1 check("R5 half odd up",    longint'(result), 16'h0002);
      rnd_mode = 2'b10; #1 check("R6 half odd conv",  longint'(result), 16'h0002);
      @(negedge clk);
      step(2'b01, 16'hFFFF, 16'h4000);
      rnd_mode = 2'b00; #1 check("R4 neg half trunc", longint'(result), 16'hFFFF);
      rnd_mode = 2'b01; #1 check("R5 neg half up",    longint'(result), 16'h0000);
      rnd_mode = 2'b10; #1 check("R6 neg half conv",  longint'(result), 16'h0000);
      @(negedge clk);
      step(2'b01, 16'h0003, 16'h3000);
      rnd_mode = 2'b01; #1 check("R5 below half", longint'(result), 16'h0001);
      rnd_mode = 2'b10; #1 check("R6 below half", longint'(result), 16'h0001);

      // negative clamp, wrap without clamp, sticky: R7 R8 R9 R1
      rnd_mode = 2'b00;
      @(negedge clk);
      step(2'b01, 16'h8000, 16'h7FFF);
      sat_en = 1'b1;
      step(2'b10, 16'h8000, 16'h7FFF);
      check("R7 clamp negative", longint'(result), 16'h8000);
      @(negedge clk);
      check("R8 sticky set", longint'(ovf_sticky), 1);
      sat_en = 1'b0; #1
      check("R7 wrap without clamp", longint'(result), 16'h0002);
      sat_en = 1'b1;
      op = 2'b00; a = 16'h7FFF; b = 16'h7FFF; in_valid = 1'b0;
      @(negedge clk);
      check("R9 idle ignored", longint'(result), 16'h8000);
      check("R9 no pulse when idle", longint'(out_valid), 0);
      check("R8 sticky held", longint'(ovf_sticky), 1);
      sat_en = 1'b0;
      step(2'b01, 16'h1000, 16'h1000);
      @(negedge clk);
      check("R8 sticky held after load", longint'(ovf_sticky), 1);
      step(2'b00, 16'h0000, 16'h0000);
      check("R1 sticky cleared", longint'(ovf_sticky), 0);
      check("R1 acc cleared", longint'(result), 0);

      // random operations against the wide-integer model: R2 R3 R4 R5 R6 R7
      for (int k = 0; k < 300; k++) begin
         logic [1:0] ro;
         ro = (k % 60 == 59) ? 2'b00 : 2'($urandom_range(1, 3));
         sat_en = 1'b0;
         case (k % 5)
            0:       step(ro, 16'h8000, 16'($urandom));
            1:       step(ro, 16'h7FFF, 16'($urandom));
            default: step(ro, 16'($urandom), 16'($urandom));
         endcase
         sweep("R3 R5 R6 R7 random");
      end

      finished = 1'b1;
      finish_run();
   end
endmodule